// File: doc/BRIEF.md
# Countdown Watchdog Timer with Selectable Expiry Action

This block is a watchdog timer that software reaches through a plain register port (valid, write, byte address, 32-bit data). It holds two words: a control/status word and a count word. Software stores a count, pulses a restart bit to copy that count into the live countdown, and then sets the run bit. While running, the countdown steps down once per time-base tick. A built-in prescaler derives ticks of 1 s, 100 ms or 10 ms from the core clock, and a parameter selects the rate.

If software does not restart the countdown in time, it runs out. The block then latches a sticky expiry flag and drives a one-clock request on one of two outputs: a system reset request or a power-off request, as chosen by the action bit. A hardware disable input blocks all counting, and its level can be read back as a status bit. The arming order is: stop with reset action, write the count, pulse restart, set run. Loading and restarting both work while the timer is stopped.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0 except bit 3, which shows `hw_disable`. The count word reads MAX_COUNT, and neither request output is high.
- R2: Control word at byte offset 0x0. Bit 0 (run: 1 running, 0 stopped) and bit 2 (action: 0 reset request, 1 power-off request) are read/write. Bit 7 and bits 4-6 and 8-31 always read 0.
- R3: Control bit 3 is read-only and reads the `hw_disable` input (1 = disabled). Writes to bit 3 have no effect.
- R4: Count word at byte offset 0x4. Only write data bits 15:0 are kept, and values above MAX_COUNT are stored as MAX_COUNT. A read returns the stored value in bits 15:0 with bits 31:16 zero.
- R5: Writing the control word with bit 7 = 1 copies the stored count into the countdown and restarts the prescaler phase. This works whether running or stopped, and a restart in the same cycle as a tick takes priority.
- R6: One tick occurs every DIV core clocks after a restart. DIV is TICKS_PER_SEC for UNIT 0 (1 s), TICKS_PER_SEC/10 for UNIT 1 (100 ms) and TICKS_PER_SEC/100 for UNIT 2 (10 ms). Other UNIT codes are rejected at elaboration.
- R7: The countdown moves only on a tick while run is 1 and `hw_disable` is 0. Clearing run freezes it at its value, and setting run again resumes from there.
- R8: A countdown loaded with N expires on the N-th counting tick (0 and 1 both expire on the first). On that tick the fired flag (bit 1) sets. In the next clock exactly one of `rst_req` (action 0) or `poff_req` (action 1) is high for one clock. The countdown then stays idle until the next restart.
- R9: The fired flag is cleared only by a control write with bit 1 = 0. A write with bit 1 = 1 leaves it unchanged, and an expiry in the same cycle as a clearing write leaves it set.
- R10: While `hw_disable` is 1, no expiry and no request occur, whatever run holds.
- R11: `bus_rdata` is 0 unless a read (`bus_valid` = 1, `bus_write` = 0) addresses offset 0x0 or 0x4. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_disable | input | 1 | Hardware disable strap, 1 blocks counting |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the request |
| rst_req | output | 1 | One-clock system reset request on expiry |
| poff_req | output | 1 | One-clock power-off request on expiry |

## Verification
The main function is tried with four countdown patterns. A full arm-and-expire run with the reset action and a short run with the power-off action tell the two outputs apart. A run that is stopped and then restarted part way shows whether the countdown freezes or quietly loses ticks. Loads of 0 and of a value above MAX_COUNT show the first-tick expiry and the saturation. Toggling the disable strap while armed separates gating by run from gating by the strap. Clearing the fired flag against writing 1 to it shows the sticky behaviour.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum int {
      UNIT_1S    = 0,
      UNIT_100MS = 1,
      UNIT_10MS  = 2
   } tick_unit_e;

   // control word field positions (software decodes these)
   localparam int CSR_RUN    = 0;
   localparam int CSR_FIRED  = 1;
   localparam int CSR_ACTION = 2;
   localparam int CSR_HWDIS  = 3;
   localparam int CSR_TRIG   = 7;

   localparam int CNT_W      = 16;
   localparam int DATA_W     = 32;

   function automatic int unsigned unit_divisor(int unsigned tps, int unit);
      case (unit)
         UNIT_1S:    return tps;
         UNIT_100MS: return tps / 10;
         default:    return tps / 100;
      endcase
   endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_every_clock
         logic unused_restart;
         assign unused_restart = restart;
         assign tick = 1'b1;
      end else begin : g_divider
         logic [PW-1:0] phase_q;
         assign tick = (phase_q == PW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             phase_q <= '0;
            else if (restart || tick) phase_q <= '0;
            else                    phase_q <= phase_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
   parameter int CW        = 16,
   parameter int MAX_COUNT = 65535
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   output logic [CW-1:0] remain,
   output logic          expire
);
   logic idle_q;

   assign expire = step && !idle_q && !reload && (remain <= CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= CW'(MAX_COUNT);
         idle_q <= 1'b0;
      end else if (reload) begin
         remain <= load_val;
         idle_q <= 1'b0;
      end else if (expire) begin
         remain <= '0;
         idle_q <= 1'b1;
      end else if (step && !idle_q) begin
         remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int MAX_COUNT = 65535
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_disable,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              expire,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              run,
   output logic              action,
   output logic              fired,
   output logic              trig,
   output logic [CNT_W-1:0]  load_val
);
   localparam logic [ADDR_W-1:0] OFS_CSR = '0;
   localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(4);

   logic wr_csr, wr_cnt, rd;
   logic [CNT_W-1:0] wr_cnt_val;
   logic [DATA_W-1:0] csr_word;
   logic [DATA_W-CNT_W-1:0] unused_hi;

   assign wr_csr = bus_valid && bus_write && (bus_addr == OFS_CSR);
   assign wr_cnt = bus_valid && bus_write && (bus_addr == OFS_CNT);
   assign rd     = bus_valid && !bus_write;
   assign trig   = wr_csr && bus_wdata[CSR_TRIG];
   assign unused_hi = bus_wdata[DATA_W-1:CNT_W];

   assign wr_cnt_val = (bus_wdata[CNT_W-1:0] > CNT_W'(MAX_COUNT))
                       ? CNT_W'(MAX_COUNT) : bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         action   <= 1'b0;
         fired    <= 1'b0;
         load_val <= CNT_W'(MAX_COUNT);
      end else begin
         if (wr_csr) begin
            run    <= bus_wdata[CSR_RUN];
            action <= bus_wdata[CSR_ACTION];
         end
         fired <= ((wr_csr && !bus_wdata[CSR_FIRED]) ? 1'b0 : fired) | expire;
         if (wr_cnt) load_val <= wr_cnt_val;
      end
   end

   always_comb begin
      csr_word             = '0;
      csr_word[CSR_RUN]    = run;
      csr_word[CSR_FIRED]  = fired;
      csr_word[CSR_ACTION] = action;
      csr_word[CSR_HWDIS]  = hw_disable;
      if (rd && bus_addr == OFS_CSR)      bus_rdata = csr_word;
      else if (rd && bus_addr == OFS_CNT) bus_rdata = {{(DATA_W-CNT_W){1'b0}}, load_val};
      else                                bus_rdata = '0;
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 100_000_000,
   parameter int          UNIT          = 0,
   parameter int          MAX_COUNT     = 65535,
   parameter int          ADDR_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_disable,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req,
   output logic              poff_req
);
   localparam int unsigned DIV = unit_divisor(TICKS_PER_SEC, UNIT);

   generate
      if (UNIT < 0 || UNIT > 2) begin : g_bad_unit
         $error("wdog_timer: UNIT must be 0, 1 or 2");
      end
      if (MAX_COUNT < 511 || MAX_COUNT > 65535) begin : g_bad_max
         $error("wdog_timer: MAX_COUNT must lie in 511..65535");
      end
      if (TICKS_PER_SEC < 100 || (TICKS_PER_SEC % 100) != 0) begin : g_bad_tps
         $error("wdog_timer: TICKS_PER_SEC must be a multiple of 100");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("wdog_timer: ADDR_W must reach offset 4");
      end
   endgenerate

   logic             run_q, action_q, fired_q, trig, tick, step, expire;
   logic [CNT_W-1:0] load_val, remain;

   wdog_regs #(.ADDR_W(ADDR_W), .MAX_COUNT(MAX_COUNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .hw_disable(hw_disable),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .expire(expire), .bus_rdata(bus_rdata),
      .run(run_q), .action(action_q), .fired(fired_q), .trig(trig),
      .load_val(load_val)
   );

   wdog_prescaler #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(trig), .tick(tick)
   );

   assign step = tick && run_q && !hw_disable;

   wdog_countdown #(.CW(CNT_W), .MAX_COUNT(MAX_COUNT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .reload(trig), .load_val(load_val),
      .step(step), .remain(remain), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         poff_req <= 1'b0;
      end else begin
         rst_req  <= expire && !action_q;
         poff_req <= expire && action_q;
      end
   end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int MAX_COUNT = 65535
) (
   input logic        clk,
   input logic        rst_n,
   input logic        hw_disable,
   input logic        run,
   input logic        trig,
   input logic        fired,
   input logic [15:0] remain,
   input logic        rst_req,
   input logic        poff_req
);
   a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_req, poff_req}));

   a_r8_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || poff_req) |=> !(rst_req || poff_req));

   a_r8_fired_with_request: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || poff_req) |-> fired);

   a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hw_disable) |-> !(rst_req || poff_req));

   a_r7_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !trig) |=> $stable(remain));

   a_r4_within_max: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= 16'(MAX_COUNT));
endmodule

bind wdog_timer wdog_timer_chk #(.MAX_COUNT(MAX_COUNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_disable(hw_disable), .run(run_q),
   .trig(trig), .fired(fired_q), .remain(remain),
   .rst_req(rst_req), .poff_req(poff_req)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
   localparam int CLK_P = 10;
   localparam int TPS   = 1000;
   localparam int UNITC = 2;
   localparam int DIV   = 10;      // 10 ms of 1000 ticks per second (R6)
   localparam int MAXC  = 600;
   localparam int WD_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_disable = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req, poff_req;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;
   string phase = "R1 reset";

   // behavioural reference state
   int m_run = 0, m_fired = 0, m_act = 0, m_load = MAXC, m_cnt = MAXC;
   int m_pre = 0, m_done = 0, m_rp = 0, m_pp = 0;

   wdog_timer #(.TICKS_PER_SEC(TPS), .UNIT(UNITC), .MAX_COUNT(MAXC), .ADDR_W(4)) u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .hw_disable(hw_disable),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req), .poff_req(poff_req)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      bit wr_csr, wr_cnt, trig_now, tick, exp_now;
      if (!rst_n) begin
         m_run = 0; m_fired = 0; m_act = 0; m_load = MAXC; m_cnt = MAXC;
         m_pre = 0; m_done = 0; m_rp = 0; m_pp = 0;
      end else begin
         wr_csr   = bus_valid && bus_write && bus_addr == 4'h0;
         wr_cnt   = bus_valid && bus_write && bus_addr == 4'h4;
         trig_now = wr_csr && bus_wdata[7];
         tick     = (m_pre == DIV - 1);
         exp_now  = 0;
         if (trig_now) begin
            m_cnt = m_load; m_pre = 0; m_done = 0;
         end else begin
            m_pre = tick ? 0 : m_pre + 1;
            if (tick && m_run != 0 && !hw_disable && m_done == 0) begin
               if (m_cnt <= 1) begin m_cnt = 0; m_done = 1; exp_now = 1; end
               else m_cnt = m_cnt - 1;
            end
         end
         m_rp = (exp_now && m_act == 0) ? 1 : 0;
         m_pp = (exp_now && m_act != 0) ? 1 : 0;
         if (wr_csr) begin
            m_run = bus_wdata[0];
            m_act = bus_wdata[2];
            if (!bus_wdata[1]) m_fired = 0;
         end
         if (exp_now) m_fired = 1;
         if (wr_cnt) m_load = (int'(bus_wdata[15:0]) > MAXC) ? MAXC : int'(bus_wdata[15:0]);
      end
   end

   function automatic logic [31:0] exp_rdata();
      logic [31:0] w;
      w = '0;
      if (bus_valid && !bus_write) begin
         if (bus_addr == 4'h0)
            w = {28'd0, hw_disable, m_act[0], m_fired[0], m_run[0]};
         else if (bus_addr == 4'h4)
            w = 32'(m_load);
      end
      return w;
   endfunction

   always begin
      @(posedge clk);
      #(CLK_P/4);
      if (!finished) begin
         compared++;
         if (bus_rdata !== exp_rdata()) begin
            mismatched++;
            $display("FAIL %s: bus_rdata actual %h expected %h", phase, bus_rdata, exp_rdata());
         end
         compared++;
         if (rst_req !== m_rp[0]) begin
            mismatched++;
            $display("FAIL %s (R8 rst_req): actual %b expected %b", phase, rst_req, m_rp[0]);
         end
         compared++;
         if (poff_req !== m_pp[0]) begin
            mismatched++;
            $display("FAIL %s (R8 poff_req): actual %b expected %b", phase, poff_req, m_pp[0]);
         end
      end
   end

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_rd(input logic [3:0] a);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run length actual %0d cycles expected below %0d", WD_CYCLES, WD_CYCLES);
      finish_run();
   end

   initial begin
      // R1: reset values
      phase = "R1 reset";
      idle(3);
      rst_n = 1'b1;
      bus_rd(4'h0); bus_rd(4'h4);

      // R4: masking of upper bits and saturation
      phase = "R4 count word";
      bus_wr(4'h4, 32'hABCD_0005); bus_rd(4'h4);
      bus_wr(4'h4, 32'h0000_FFFF); bus_rd(4'h4);
      bus_wr(4'h4, 32'h0000_0259); bus_rd(4'h4);

      // R2 / R3: read/write bits, read-only bit 3, zero bits
      phase = "R2 R3 control bits";
      bus_wr(4'h0, 32'hFFFF_FF75); bus_rd(4'h0);
      bus_wr(4'h0, 32'h0000_0008); bus_rd(4'h0);

      // R11: unmapped offset
      phase = "R11 unmapped";
      bus_wr(4'h8, 32'hFFFF_FFFF); bus_rd(4'h8); bus_rd(4'h0); bus_rd(4'h4);

      // R5 R6 R8: arm with reset action, expire
      phase = "R5 R6 R8 reset action";
      bus_wr(4'h0, 32'h0);
      bus_wr(4'h4, 32'd3);
      bus_wr(4'h0, 32'h80);
      bus_wr(4'h0, 32'h01);
      idle(45);
      bus_rd(4'h0);

      // R9: sticky fired flag
      phase = "R9 fired flag";
      bus_wr(4'h0, 32'h03); bus_rd(4'h0);
      bus_wr(4'h0, 32'h01); bus_rd(4'h0);

      // R8: power-off action
      phase = "R8 power-off action";
      bus_wr(4'h4, 32'd2);
      bus_wr(4'h0, 32'h84);
      bus_wr(4'h0, 32'h05);
      idle(35);
      bus_rd(4'h0);
      bus_wr(4'h0, 32'h04);

      // R7: freeze and resume
      phase = "R7 freeze";
      bus_wr(4'h4, 32'd4);
      bus_wr(4'h0, 32'h84);
      bus_wr(4'h0, 32'h05);
      idle(15);
      bus_wr(4'h0, 32'h04);
      idle(60);
      bus_wr(4'h0, 32'h05);
      idle(45);
      bus_wr(4'h0, 32'h04);

      // R5: retrigger while running postpones expiry
      phase = "R5 retrigger";
      bus_wr(4'h4, 32'd3);
      bus_wr(4'h0, 32'h81);
      idle(20);
      bus_wr(4'h0, 32'h81);
      idle(20);
      bus_wr(4'h0, 32'h81);
      idle(40);

      // R10: hardware disable blocks counting
      phase = "R10 disabled";
      bus_wr(4'h0, 32'h00);
      hw_disable = 1'b1;
      bus_wr(4'h4, 32'd1);
      bus_wr(4'h0, 32'h80);
      bus_wr(4'h0, 32'h01);
      idle(40);
      bus_rd(4'h0);
      hw_disable = 1'b0;
      idle(25);
      bus_rd(4'h0);

      // R8: zero count expires on first tick
      phase = "R8 zero count";
      bus_wr(4'h0, 32'h00);
      bus_wr(4'h4, 32'd0);
      bus_wr(4'h0, 32'h80);
      bus_wr(4'h0, 32'h01);
      idle(20);
      bus_rd(4'h0);

      // R9: expiry wins over a clearing write in the same cycle (exercised by timing)
      phase = "R9 clear and re-expire";
      bus_wr(4'h0, 32'h00);
      bus_wr(4'h4, 32'd1);
      bus_wr(4'h0, 32'h81);
      idle(8);
      bus_wr(4'h0, 32'h01);
      bus_wr(4'h0, 32'h01);
      idle(20);
      bus_rd(4'h0);

      idle(3);
      finish_run();
   end
endmodule